// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Timer

This block is a bus-mapped watchdog. Software loads a 32-bit down-counter with a tick count and reloads it often enough that it never reaches zero. If it does reach zero, the block latches a sticky expiry flag, holds a timeout interrupt, and, if the system-reset path is armed, emits a one-cycle reset request to the chip's reset controller.

A second down-counter runs alongside the watchdog and gives an early warning. Software loads it with the watchdog load value minus the warning interval, so it reaches zero first and raises its own interrupt. Each counter takes its ticks either from the core clock divided by a power of two or from a fixed-rate reference strobe. The choice is made per counter.

Registers are reached through a single-cycle 32-bit bus with byte offsets. A write takes effect at the clock edge where `bus_sel_i` and `bus_we_i` are both high. Reads are combinational from `bus_addr_i`.

Top module: `wdog_pretimer`

## Requirements
- R1: After reset, every register reads 0, both counters read 0, and `irq_wd_o`, `irq_pre_o` and `sys_rst_o` are low.
- R2: Control register at 0x00 holds these fields, and all other bits read 0:
  - bit 8: watchdog run.
  - bit 2: early-warning run.
  - bit 10: watchdog uses the reference strobe.
  - bit 12: early-warning timer uses the reference strobe.
  - bits 20:16: prescale ratio.

  Only bit 8 of the reset-arm register at 0x40 is kept, and only bit 10 of the reset-block register at 0x44.
- R3: A write to 0x34 loads the watchdog counter, and a read returns the ticks left. While bit 8 is set, each tick lowers the count by one. While bit 8 is clear, the count holds.
- R4: With its reference-select bit set, a counter decrements once per cycle in which `ref_tick_i` is high. Otherwise it decrements once every 2^ratio core cycles (ratio 0 means every cycle).
- R5: A counter that reaches 0 stays at 0 and does not wrap. A watchdog step from 1 to 0 sets status bit 31, and `irq_wd_o` equals that bit.
- R6: The early-warning counter at 0x1C, run by bit 2, sets status bit 8 on its step from 1 to 0. `irq_pre_o` equals that bit, and the watchdog flag is unaffected.
- R7: A status write clears each flag whose bit is written 0 and leaves flags written 1 unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: `sys_rst_o` is high for exactly one cycle, the one after the watchdog steps to 0, and only if 0x40 bit 8 is set and 0x44 bit 10 is clear.
- R9: Rewriting 0x34 while the watchdog runs restarts the countdown from the new value, so regular rewrites prevent expiry.
- R10: The load value 0xFFFFFFFF is accepted and counts down from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Fixed-rate reference strobe, one cycle per tick |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_wd_o | output | 1 | Watchdog timeout interrupt, level |
| irq_pre_o | output | 1 | Early-warning interrupt, level |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Two events can land on the same clock edge: the watchdog stepping from 1 to 0, and a software status write that clears the expiry flag. The bench provokes this by raising the reference strobe and driving a status write of 0 in the same cycle, with the counter loaded to 1. Hardware setting takes priority, so the flag must read back as set afterwards. The bench judges the case at the ports: the status readback and the level of `irq_wd_o`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned RATIO_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PRE   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WD    = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_ARM   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_BLOCK = 8'h44;

  localparam int unsigned B_PRE_RUN = 2;
  localparam int unsigned B_WD_RUN  = 8;
  localparam int unsigned B_WD_REF  = 10;
  localparam int unsigned B_PRE_REF = 12;
  localparam int unsigned B_RATIO   = 16;
  localparam int unsigned B_PRE_EXP = 8;
  localparam int unsigned B_WD_EXP  = 31;
  localparam int unsigned B_ARM     = 8;
  localparam int unsigned B_BLOCK   = 10;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               pre_ref;
    logic               wd_ref;
    logic               wd_run;
    logic               pre_run;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned RATIO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  localparam int unsigned CNT_W = 1 << RATIO_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // tick when the low ratio bits of the free counter are all ones
  assign low_mask = (CNT_W'(1) << ratio_i) - CNT_W'(1);
  assign tick_o   = &(cnt_q | ~low_mask);

  // R4
  ratio0_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == '0) |-> tick_o);
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step     = run_i && tick_i && (cnt_q != '0) && !load_i;
  assign expire_o = step && (cnt_q == W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end

  // R5
  stop_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_pretimer.sv
module wdog_pretimer
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_wd_o,
  output logic              irq_pre_o,
  output logic              sys_rst_o
);
  ctrl_t             ctrl_q;
  logic              arm_q, block_q;
  logic              wd_flag_q, pre_flag_q;
  logic              rst_q;
  logic              wr;
  logic              presc_tick, wd_tick, pre_tick;
  logic              wd_exp, pre_exp;
  logic [DATA_W-1:0] wd_cnt, pre_cnt;
  logic              unused_wdata;

  assign wr           = bus_sel_i && bus_we_i;
  assign unused_wdata = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      arm_q   <= 1'b0;
      block_q <= 1'b0;
    end else if (wr) begin
      if (bus_addr_i == OFF_CTRL) begin
        ctrl_q.ratio   <= bus_wdata_i[B_RATIO +: RATIO_W];
        ctrl_q.pre_ref <= bus_wdata_i[B_PRE_REF];
        ctrl_q.wd_ref  <= bus_wdata_i[B_WD_REF];
        ctrl_q.wd_run  <= bus_wdata_i[B_WD_RUN];
        ctrl_q.pre_run <= bus_wdata_i[B_PRE_RUN];
      end
      if (bus_addr_i == OFF_ARM)   arm_q   <= bus_wdata_i[B_ARM];
      if (bus_addr_i == OFF_BLOCK) block_q <= bus_wdata_i[B_BLOCK];
    end
  end

  wdog_prescaler #(.RATIO_W(RATIO_W)) presc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ctrl_q.ratio),
    .tick_o  (presc_tick)
  );

  assign wd_tick  = ctrl_q.wd_ref  ? ref_tick_i : presc_tick;
  assign pre_tick = ctrl_q.pre_ref ? ref_tick_i : presc_tick;

  wdog_downcnt #(.W(DATA_W)) wd_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr && bus_addr_i == OFF_WD),
    .load_val_i (bus_wdata_i),
    .run_i      (ctrl_q.wd_run),
    .tick_i     (wd_tick),
    .cnt_o      (wd_cnt),
    .expire_o   (wd_exp)
  );

  wdog_downcnt #(.W(DATA_W)) pre_cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr && bus_addr_i == OFF_PRE),
    .load_val_i (bus_wdata_i),
    .run_i      (ctrl_q.pre_run),
    .tick_i     (pre_tick),
    .cnt_o      (pre_cnt),
    .expire_o   (pre_exp)
  );

  // status: write-zero clears, hardware set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_flag_q  <= 1'b0;
      pre_flag_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      wd_flag_q  <= wd_exp  | (wd_flag_q  & ~(wr && bus_addr_i == OFF_STAT && !bus_wdata_i[B_WD_EXP]));
      pre_flag_q <= pre_exp | (pre_flag_q & ~(wr && bus_addr_i == OFF_STAT && !bus_wdata_i[B_PRE_EXP]));
      rst_q      <= wd_exp && arm_q && !block_q;
    end
  end

  assign irq_wd_o  = wd_flag_q;
  assign irq_pre_o = pre_flag_q;
  assign sys_rst_o = rst_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_CTRL: begin
        bus_rdata_o[B_RATIO +: RATIO_W] = ctrl_q.ratio;
        bus_rdata_o[B_PRE_REF]          = ctrl_q.pre_ref;
        bus_rdata_o[B_WD_REF]           = ctrl_q.wd_ref;
        bus_rdata_o[B_WD_RUN]           = ctrl_q.wd_run;
        bus_rdata_o[B_PRE_RUN]          = ctrl_q.pre_run;
      end
      OFF_STAT: begin
        bus_rdata_o[B_WD_EXP]  = wd_flag_q;
        bus_rdata_o[B_PRE_EXP] = pre_flag_q;
      end
      OFF_PRE:   bus_rdata_o = pre_cnt;
      OFF_WD:    bus_rdata_o = wd_cnt;
      OFF_ARM:   bus_rdata_o[B_ARM]   = arm_q;
      OFF_BLOCK: bus_rdata_o[B_BLOCK] = block_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  // R8
  rst_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);
  // R8
  rst_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_q |=> !sys_rst_o);
  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp |=> irq_wd_o);
  // R6
  pre_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_exp |=> irq_pre_o);
endmodule

// File: tb/wdog_pretimer_tb_top.sv
`timescale 1ns/1ps
module wdog_pretimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_wd, irq_pre, sys_rst;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_pretimer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_wd_o(irq_wd), .irq_pre_o(irq_pre), .sys_rst_o(sys_rst)
  );

  typedef struct packed { logic [7:0] a; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8'h00, 32'hFFFF_FFFF, 32'h001F_1504},
    '{8'h00, 32'h0000_0000, 32'h0000_0000},
    '{8'h40, 32'hFFFF_FFFF, 32'h0000_0100},
    '{8'h44, 32'hFFFF_FFFF, 32'h0000_0400},
    '{8'h44, 32'h0000_0000, 32'h0000_0000},
    '{8'h40, 32'h0000_0000, 32'h0000_0000},
    '{8'h34, 32'h1234_5678, 32'h1234_5678},
    '{8'h1C, 32'hCAFE_F00D, 32'hCAFE_F00D},
    '{8'h34, 32'h0000_0000, 32'h0000_0000},
    '{8'h1C, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // n reference ticks; counts reset pulses seen in the following cycles
  task automatic ticks(input int n, output int pulses);
    pulses = 0;
    @(negedge clk);
    ref_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst) pulses++;
    end
    ref_tick = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sys_rst) pulses++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (VECS[i]) begin
      rd(VECS[i].a, v);
      check("R1 reset reg", v, 32'h0);
    end
    rd(8'h04, v); check("R1 status", v, 32'h0);
    check("R1 outputs", {29'h0, irq_wd, irq_pre, sys_rst}, 32'h0);

    // R2 table walk
    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].wd);
      rd(VECS[i].a, v);
      check("R2 readback", v, VECS[i].exp);
    end

    // R4 reference source, R3 hold
    wr(8'h00, 32'h0000_0500);
    wr(8'h34, 32'd10);
    repeat (5) @(negedge clk);
    rd(8'h34, v); check("R4 no strobe no step", v, 32'd10);
    ticks(3, p);
    rd(8'h34, v); check("R3 R4 three ticks", v, 32'd7);
    wr(8'h00, 32'h0000_0400);
    ticks(3, p);
    rd(8'h34, v); check("R3 hold when stopped", v, 32'd7);

    // R4 prescaler ratio 5 and ratio 0
    wr(8'h00, 32'h0005_0100);
    wr(8'h34, 32'd1000);
    rd(8'h34, v); repeat (31) @(negedge clk); rd(8'h34, v2);
    check("R4 ratio5 per 32", v - v2, 32'd1);
    rd(8'h34, v); repeat (63) @(negedge clk); rd(8'h34, v2);
    check("R4 ratio5 per 64", v - v2, 32'd2);
    wr(8'h00, 32'h0000_0100);
    rd(8'h34, v); repeat (9) @(negedge clk); rd(8'h34, v2);
    check("R4 ratio0 per cycle", v - v2, 32'd10);
    wr(8'h00, 32'h0000_0004);
    wr(8'h1C, 32'd500);
    rd(8'h1C, v); repeat (9) @(negedge clk); rd(8'h1C, v2);
    check("R4 pre prescaled", v - v2, 32'd10);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);

    // R5 R8 expiry with reset armed
    wr(8'h40, 32'h100);
    wr(8'h00, 32'h0000_0500);
    wr(8'h34, 32'd3);
    ticks(8, p);
    check("R8 one reset pulse", p, 32'd1);
    rd(8'h34, v); check("R5 stays at zero", v, 32'h0);
    rd(8'h04, v); check("R5 status bit31", v, 32'h8000_0000);
    check("R5 irq_wd level", {31'h0, irq_wd}, 32'h1);
    // R7 write-one keeps, write-zero clears
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R7 write one keeps", v, 32'h8000_0000);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R7 write zero clears", v, 32'h0);
    check("R7 irq_wd low", {31'h0, irq_wd}, 32'h0);

    // R8 blocked and unarmed
    wr(8'h44, 32'h400);
    wr(8'h34, 32'd2);
    ticks(5, p);
    check("R8 blocked no pulse", p, 32'd0);
    check("R8 blocked irq still", {31'h0, irq_wd}, 32'h1);
    wr(8'h04, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h34, 32'd2);
    ticks(5, p);
    check("R8 unarmed no pulse", p, 32'd0);
    wr(8'h04, 32'h0);

    // R6 early warning first
    wr(8'h00, 32'h0000_1504);
    wr(8'h34, 32'd10);
    wr(8'h1C, 32'd4);
    ticks(4, p);
    rd(8'h04, v); check("R6 pre flag only", v, 32'h0000_0100);
    check("R6 irqs", {30'h0, irq_wd, irq_pre}, 32'h1);
    rd(8'h34, v); check("R6 wd in parallel", v, 32'd6);
    ticks(6, p);
    rd(8'h04, v); check("R6 both flags", v, 32'h8000_0100);
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, v); check("R7 selective clear", v, 32'h8000_0000);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0500);

    // R9 keep-alive
    wr(8'h34, 32'd5);
    for (int k = 0; k < 4; k++) begin
      ticks(3, p);
      wr(8'h34, 32'd5);
    end
    rd(8'h34, v); check("R9 reloaded", v, 32'd5);
    check("R9 never expired", {31'h0, irq_wd}, 32'h0);

    // R10 full range
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); check("R10 load max", v, 32'hFFFF_FFFF);
    ticks(1, p);
    rd(8'h34, v); check("R10 first step", v, 32'hFFFF_FFFE);

    // R7 expiry and clearing write on the same edge
    wr(8'h34, 32'd1);
    @(negedge clk);
    ref_tick = 1'b1; sel = 1'b1; we = 1'b1; addr = 8'h04; wdata = 32'h0;
    @(negedge clk);
    ref_tick = 1'b0; sel = 1'b0; we = 1'b0;
    rd(8'h04, v); check("R7 set wins over clear", v, 32'h8000_0000);
    check("R7 irq after collision", {31'h0, irq_wd}, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule